// File: doc/BRIEF.md
# Burst Stream Sideband Tracker

This block sits on a 128-bit streaming interface where bursts are framed by single-cycle start and end pulses and a per-cycle valid qualifier. An 8-bit sideband called sync travels with the data, and its meaning depends on the framing. On the cycle that opens a burst it names the logical channel the burst belongs to. On the cycle that closes a burst it gives the number of unused bytes in the final beat. The tracker reads the sideband at those two points. It tags every valid beat inside the burst with the latched channel and reports the empty count of the last beat with a one-cycle strobe. Because the channel is latched per burst, several logical channels can share the stream by taking turns burst by burst.

A two-state machine follows the framing. In ST_IDLE no burst is open. The transition OPEN_BURST (start without end) goes to ST_OPEN. The transition SINGLE_BEAT (start and end together) stays in ST_IDLE. In ST_OPEN, CLOSE_BURST (end without start) returns to ST_IDLE. RESTART (start while open) reloads the channel, flags an error, and either stays in ST_OPEN or, if end is also high, returns to ST_IDLE as a single-beat burst.

Framing violations set sticky error flags, which are cleared by a clear input. All outputs are registered one cycle after the inputs that cause them.

Top module: `burst_sideband_tracker`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid, out_last, out_empty_stb, out_empty, out_chan, out_data and err_flags are all zero.
- R2: A start cycle latches in_sync as the channel. Each valid beat of the burst appears on out_data with out_valid high one cycle later, and out_chan equals that channel.
- R3: A cycle inside an open burst with in_valid low produces no output beat (out_valid low one cycle later), and the burst stays open.
- R4: An end cycle of an open burst closes it. One cycle later out_empty_stb is high for one cycle and out_empty holds in_sync from that end cycle. If that end beat was valid, out_last is high together with out_valid.
- R5: An empty value above 15 on a closing end cycle is reported as 15 and sets err_flags bit 3.
- R6: Start and end on the same cycle form a one-beat burst. The channel is taken from in_sync, out_empty is 0 with out_empty_stb high, err_flags bit 3 stays clear, and no burst is left open.
- R7: in_valid high while no burst is open, and without a start on that cycle, drops the beat (out_valid stays low) and sets err_flags bit 2.
- R8: A start while a burst is open sets err_flags bit 0 and restarts the burst with the new in_sync as the channel.
- R9: An end without a start while no burst is open sets err_flags bit 1 and produces neither an empty strobe nor a beat.
- R10: Error flags stay set until err_clear is high. A clear zeroes them one cycle later, except that an error raised on the same cycle as the clear is kept.
- R11: Reset closes an open burst, so a valid beat after reset that arrives without a start is dropped as a stray beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 128 | Incoming data beat |
| in_sop | input | 1 | Start-of-burst pulse |
| in_eop | input | 1 | End-of-burst pulse |
| in_valid | input | 1 | Beat carries data |
| in_sync | input | 8 | Sideband: channel on start, empty count on end |
| err_clear | input | 1 | Clears the sticky error flags |
| out_data | output | 128 | Last forwarded data beat |
| out_valid | output | 1 | out_data holds a beat forwarded this cycle |
| out_last | output | 1 | Forwarded beat was the burst's end beat |
| out_chan | output | 8 | Channel of the current or most recent burst |
| out_empty | output | 4 | Empty-byte count of the last closed burst |
| out_empty_stb | output | 1 | One-cycle pulse when out_empty is updated |
| err_flags | output | 4 | Sticky errors: 0 double start, 1 orphan end, 2 stray valid, 3 empty overflow |

## Verification
Constrained random traffic with rare start and end pulses and frequent valid gaps checks tagging and gap handling over long bursts. Random sync values up to 31 push about half of the closing beats past the saturation limit. Random framing that includes illegal orders separates the RESTART path from the orphan-end and stray-valid paths, because each sets a different error bit. Directed sequences cover a one-beat burst with a large sync value, which separates forced zero from saturation, a clear that coincides with a new error, and a reset in the middle of a burst.

// File: rtl/bst_pkg.sv
package bst_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_OPEN = 1'b1
    } bst_state_e;

    localparam int ERR_W          = 4;
    localparam int ERR_DUP_SOP    = 0;
    localparam int ERR_ORPHAN_EOP = 1;
    localparam int ERR_STRAY      = 2;
    localparam int ERR_EMPTY_OVF  = 3;
endpackage

// File: rtl/bst_frame_fsm.sv
module bst_frame_fsm
    import bst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sop,
    input  logic       eop,
    input  logic       valid,
    output bst_state_e state,
    output logic       accept_beat,
    output logic       load_chan,
    output logic       close_burst,
    output logic       one_beat,
    output logic       dup_sop,
    output logic       orphan_eop,
    output logic       stray_valid
);
    bst_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        accept_beat = 1'b0;
        load_chan   = 1'b0;
        close_burst = 1'b0;
        one_beat    = 1'b0;
        dup_sop     = 1'b0;
        orphan_eop  = 1'b0;
        stray_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sop) begin
                    load_chan   = 1'b1;
                    accept_beat = valid;
                    if (eop) begin
                        one_beat    = 1'b1;
                        close_burst = 1'b1;
                    end else begin
                        state_d = ST_OPEN;
                    end
                end else begin
                    orphan_eop  = eop;
                    stray_valid = valid;
                end
            end
            ST_OPEN: begin
                accept_beat = valid;
                if (sop) begin
                    dup_sop   = 1'b1;
                    load_chan = 1'b1;
                    if (eop) begin
                        one_beat    = 1'b1;
                        close_burst = 1'b1;
                        state_d     = ST_IDLE;
                    end
                end else if (eop) begin
                    close_burst = 1'b1;
                    state_d     = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state = state_q;

    // R7: a beat arriving in the idle state without a start is never accepted
    a_r7_no_accept_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !sop) |-> !accept_beat);
endmodule

// File: rtl/bst_beat_tagger.sv
module bst_beat_tagger #(
    parameter int DATA_W = 128,
    parameter int SYNC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_beat,
    input  logic              load_chan,
    input  logic              close_burst,
    input  logic [DATA_W-1:0] in_data,
    input  logic [SYNC_W-1:0] in_sync,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_last,
    output logic [SYNC_W-1:0] out_chan
);
    logic [DATA_W-1:0] data_q;
    logic [SYNC_W-1:0] chan_q;
    logic              valid_q, last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            chan_q  <= '0;
            valid_q <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            valid_q <= accept_beat;
            last_q  <= accept_beat & close_burst;
            if (accept_beat) data_q <= in_data;
            if (load_chan)   chan_q <= in_sync;
        end
    end

    assign out_data  = data_q;
    assign out_valid = valid_q;
    assign out_last  = last_q;
    assign out_chan  = chan_q;

    // R4: the last-beat marker only accompanies a forwarded beat
    a_r4_last_with_valid: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);
endmodule

// File: rtl/bst_empty_unit.sv
module bst_empty_unit #(
    parameter int SYNC_W  = 8,
    parameter int EMPTY_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               close_burst,
    input  logic               one_beat,
    input  logic [SYNC_W-1:0]  in_sync,
    output logic [EMPTY_W-1:0] out_empty,
    output logic               out_empty_stb,
    output logic               overflow
);
    localparam int MAX_EMPTY = (1 << EMPTY_W) - 1;

    logic [EMPTY_W-1:0] empty_q, empty_d;
    logic               stb_q;
    logic               too_big;

    always_comb begin
        too_big = (int'(in_sync) > MAX_EMPTY);
        if (one_beat)     empty_d = '0;
        else if (too_big) empty_d = EMPTY_W'(MAX_EMPTY);
        else              empty_d = in_sync[EMPTY_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q <= '0;
            stb_q   <= 1'b0;
        end else begin
            stb_q <= close_burst;
            if (close_burst) empty_q <= empty_d;
        end
    end

    assign overflow      = close_burst & ~one_beat & too_big;
    assign out_empty     = empty_q;
    assign out_empty_stb = stb_q;

    // R6: a one-beat burst reports zero empty bytes
    a_r6_single_zero: assert property (@(posedge clk) disable iff (rst)
        (close_burst && one_beat) |=> (out_empty_stb && out_empty == '0));
endmodule

// File: rtl/bst_err_flags.sv
module bst_err_flags #(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [ERR_W-1:0] set_vec,
    output logic [ERR_W-1:0] flags
);
    logic [ERR_W-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (clear ? '0 : flags_q) | set_vec;
    end

    assign flags = flags_q;

    // R10: without a clear, no flag ever falls
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        !$past(clear) |-> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/burst_sideband_tracker.sv
module burst_sideband_tracker
    import bst_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int SYNC_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [DATA_W-1:0]           in_data,
    input  logic                        in_sop,
    input  logic                        in_eop,
    input  logic                        in_valid,
    input  logic [SYNC_W-1:0]           in_sync,
    input  logic                        err_clear,
    output logic [DATA_W-1:0]           out_data,
    output logic                        out_valid,
    output logic                        out_last,
    output logic [SYNC_W-1:0]           out_chan,
    output logic [$clog2(DATA_W/8)-1:0] out_empty,
    output logic                        out_empty_stb,
    output logic [ERR_W-1:0]            err_flags
);
    localparam int BYTES   = DATA_W / 8;
    localparam int EMPTY_W = $clog2(BYTES);

    bst_state_e       state;
    logic             accept_beat, load_chan, close_burst, one_beat;
    logic             dup_sop, orphan_eop, stray_valid, overflow;
    logic [ERR_W-1:0] err_set;

    bst_frame_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sop         (in_sop),
        .eop         (in_eop),
        .valid       (in_valid),
        .state       (state),
        .accept_beat (accept_beat),
        .load_chan   (load_chan),
        .close_burst (close_burst),
        .one_beat    (one_beat),
        .dup_sop     (dup_sop),
        .orphan_eop  (orphan_eop),
        .stray_valid (stray_valid)
    );

    bst_beat_tagger #(.DATA_W(DATA_W), .SYNC_W(SYNC_W)) u_tag (
        .clk         (clk),
        .rst         (rst),
        .accept_beat (accept_beat),
        .load_chan   (load_chan),
        .close_burst (close_burst),
        .in_data     (in_data),
        .in_sync     (in_sync),
        .out_data    (out_data),
        .out_valid   (out_valid),
        .out_last    (out_last),
        .out_chan    (out_chan)
    );

    bst_empty_unit #(.SYNC_W(SYNC_W), .EMPTY_W(EMPTY_W)) u_empty (
        .clk           (clk),
        .rst           (rst),
        .close_burst   (close_burst),
        .one_beat      (one_beat),
        .in_sync       (in_sync),
        .out_empty     (out_empty),
        .out_empty_stb (out_empty_stb),
        .overflow      (overflow)
    );

    always_comb begin
        err_set                 = '0;
        err_set[ERR_DUP_SOP]    = dup_sop;
        err_set[ERR_ORPHAN_EOP] = orphan_eop;
        err_set[ERR_STRAY]      = stray_valid;
        err_set[ERR_EMPTY_OVF]  = overflow;
    end

    bst_err_flags #(.ERR_W(ERR_W)) u_err (
        .clk     (clk),
        .rst     (rst),
        .clear   (err_clear),
        .set_vec (err_set),
        .flags   (err_flags)
    );

    // R3: an output beat always traces back to a valid input cycle
    a_r3_beat_needs_valid: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R4: the empty strobe always follows an end pulse
    a_r4_stb_after_eop: assert property (@(posedge clk) disable iff (rst)
        out_empty_stb |-> $past(in_eop));

    // R2: the channel holds while an open burst continues without a new start
    a_r2_chan_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OPEN && !in_sop) |=> $stable(out_chan));

    // R9: an orphan end leaves no strobe and raises its flag
    a_r9_orphan_end: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && in_eop && !in_sop) |=> (!out_empty_stb && err_flags[ERR_ORPHAN_EOP]));

    // R5: an oversized empty on a closing beat saturates and flags
    a_r5_saturate: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OPEN && in_eop && !in_sop && int'(in_sync) > BYTES - 1)
        |=> (out_empty == EMPTY_W'(BYTES - 1) && err_flags[ERR_EMPTY_OVF]));
endmodule

// File: tb/burst_sideband_tracker_test.sv
module burst_sideband_tracker_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] in_data = '0;
    logic         in_sop = 1'b0, in_eop = 1'b0, in_valid = 1'b0, err_clear = 1'b0;
    logic [7:0]   in_sync = '0;
    logic [127:0] out_data;
    logic         out_valid, out_last, out_empty_stb;
    logic [7:0]   out_chan;
    logic [3:0]   out_empty;
    logic [3:0]   err_flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    bit           m_open;
    logic [7:0]   m_chan;
    logic [127:0] m_data;
    logic [3:0]   m_empty, m_err;
    bit           e_valid, e_last, e_stb;

    always #4 clk = ~clk;

    burst_sideband_tracker uut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .in_valid(in_valid), .in_sync(in_sync), .err_clear(err_clear),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
        .out_chan(out_chan), .out_empty(out_empty), .out_empty_stb(out_empty_stb),
        .err_flags(err_flags)
    );

    function automatic logic [3:0] sat_empty(input logic [7:0] s);
        return (s > 8'd15) ? 4'd15 : s[3:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_open = 0; m_chan = '0; m_data = '0; m_empty = '0; m_err = '0;
        e_valid = 0; e_last = 0; e_stb = 0;
    endtask

    task automatic model_step(input bit sop, input bit eop, input bit v,
                              input logic [7:0] s, input logic [127:0] d, input bit clr);
        logic [3:0] ne;
        ne = '0; e_valid = 0; e_last = 0; e_stb = 0;
        if (sop) begin
            if (m_open) ne[0] = 1;
            m_chan = s;
            if (v) begin e_valid = 1; m_data = d; end
            if (eop) begin e_stb = 1; m_empty = 4'd0; e_last = v; m_open = 0; end
            else m_open = 1;
        end else if (m_open) begin
            if (v) begin e_valid = 1; m_data = d; end
            if (eop) begin
                e_stb = 1; m_empty = sat_empty(s); e_last = v; m_open = 0;
                if (s > 8'd15) ne[3] = 1;
            end
        end else begin
            if (eop) ne[1] = 1;
            if (v)   ne[2] = 1;
        end
        m_err = (clr ? 4'd0 : m_err) | ne;
    endtask

    task automatic compare_all();
        chk(out_valid == e_valid, "R2/R3 out_valid", 128'(out_valid), 128'(e_valid));
        chk(out_data == m_data, "R2 out_data", out_data, m_data);
        chk(out_chan == m_chan, "R2 out_chan", 128'(out_chan), 128'(m_chan));
        chk(out_last == e_last, "R4 out_last", 128'(out_last), 128'(e_last));
        chk(out_empty_stb == e_stb, "R4 out_empty_stb", 128'(out_empty_stb), 128'(e_stb));
        chk(out_empty == m_empty, "R4/R5 out_empty", 128'(out_empty), 128'(m_empty));
        chk(err_flags == m_err, "R10 err_flags", 128'(err_flags), 128'(m_err));
    endtask

    // drive at negedge, check after the next rising edge
    task automatic step(input bit sop, input bit eop, input bit v,
                        input logic [7:0] s, input logic [127:0] d, input bit clr);
        in_sop = sop; in_eop = eop; in_valid = v; in_sync = s; in_data = d; err_clear = clr;
        model_step(sop, eop, v, s, d, clr);
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_sop = 0; in_eop = 0; in_valid = 0; err_clear = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        @(negedge clk);
        @(negedge clk);
        // R1: values during reset
        chk(out_valid == 0 && out_empty_stb == 0 && out_last == 0, "R1 strobes in reset",
            {out_valid, out_last, out_empty_stb}, 0);
        chk(err_flags == 0 && out_chan == 0 && out_empty == 0 && out_data == 0, "R1 regs in reset",
            {err_flags, out_chan, out_empty}, 0);
        do_reset();
        chk(out_valid == 0 && err_flags == 0, "R1 after reset", {out_valid, err_flags}, 0);

        // R2/R3/R4: normal burst on channel 5 with a gap
        step(1, 0, 1, 8'd5, 128'hA1, 0);
        chk(out_valid && out_chan == 8'd5 && out_data == 128'hA1, "R2 first beat tagged",
            {out_chan, out_data[7:0]}, {8'd5, 8'hA1});
        step(0, 0, 0, 8'd9, 128'hBB, 0);
        chk(!out_valid, "R3 gap not forwarded", 128'(out_valid), 0);
        step(0, 0, 1, 8'd9, 128'hA2, 0);
        chk(out_valid && out_chan == 8'd5 && out_data == 128'hA2, "R3 burst still open",
            {out_chan, out_data[7:0]}, {8'd5, 8'hA2});
        step(0, 1, 1, 8'd3, 128'hA3, 0);
        chk(out_last && out_empty_stb && out_empty == 4'd3, "R4 close with empty 3",
            {out_last, out_empty_stb, out_empty}, {1'b1, 1'b1, 4'd3});
        step(0, 0, 0, 8'd0, 128'h0, 0);
        chk(!out_empty_stb, "R4 strobe one cycle", 128'(out_empty_stb), 0);

        // R5: empty overflow
        step(1, 0, 1, 8'd7, 128'hC1, 0);
        step(0, 1, 1, 8'd20, 128'hC2, 0);
        chk(out_empty == 4'd15 && err_flags[3], "R5 saturated empty", {err_flags, out_empty}, {4'b1000, 4'd15});

        // R10: clear, then set-wins
        step(0, 0, 0, 8'd0, 128'h0, 1);
        chk(err_flags == 0, "R10 clear", 128'(err_flags), 0);
        step(0, 0, 1, 8'd0, 128'hD0, 0);
        step(0, 0, 1, 8'd0, 128'hD1, 1);
        chk(err_flags == 4'b0100, "R10 set wins over clear", 128'(err_flags), 128'h4);
        step(0, 0, 0, 8'd0, 128'h0, 1);

        // R6: one-beat burst with large sync
        step(1, 1, 1, 8'd200, 128'hE1, 0);
        chk(out_chan == 8'd200 && out_empty == 0 && out_empty_stb && !err_flags[3], "R6 one beat",
            {out_chan, out_empty, err_flags}, {8'd200, 4'd0, 4'd0});
        step(0, 0, 1, 8'd0, 128'hE2, 0);
        chk(!out_valid && err_flags[2], "R6 closed after one beat / R7 stray", {out_valid, err_flags}, {1'b0, 4'b0100});
        step(0, 0, 0, 8'd0, 128'h0, 1);

        // R7 alone
        step(0, 0, 1, 8'd1, 128'hF0, 0);
        chk(!out_valid && err_flags == 4'b0100, "R7 stray valid dropped", {out_valid, err_flags}, {1'b0, 4'b0100});
        step(0, 0, 0, 8'd0, 128'h0, 1);

        // R9: orphan end
        step(0, 1, 0, 8'd4, 128'h0, 0);
        chk(!out_empty_stb && err_flags == 4'b0010, "R9 orphan end", {out_empty_stb, err_flags}, {1'b0, 4'b0010});
        step(0, 0, 0, 8'd0, 128'h0, 1);

        // R8: restart while open
        step(1, 0, 1, 8'd10, 128'h11, 0);
        step(1, 0, 1, 8'd11, 128'h12, 0);
        chk(out_chan == 8'd11 && err_flags == 4'b0001 && out_valid, "R8 restart", {out_chan, err_flags}, {8'd11, 4'b0001});
        step(0, 1, 1, 8'd2, 128'h13, 0);
        chk(out_chan == 8'd11 && out_empty == 4'd2, "R8 restarted burst closes", {out_chan, out_empty}, {8'd11, 4'd2});

        // R11: reset mid-burst
        step(1, 0, 1, 8'd33, 128'h21, 0);
        do_reset();
        step(0, 0, 1, 8'd0, 128'h22, 0);
        chk(!out_valid && err_flags == 4'b0100, "R11 reset closes burst", {out_valid, err_flags}, {1'b0, 4'b0100});
        step(0, 0, 0, 8'd0, 128'h0, 1);

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            bit sop, eop, v, clr;
            sop = ($urandom_range(0, 99) < 10);
            eop = ($urandom_range(0, 99) < (m_open ? 15 : 3));
            v   = ($urandom_range(0, 99) < (m_open || sop ? 75 : 4));
            clr = ($urandom_range(0, 99) < 3);
            step(sop, eop, v, 8'($urandom_range(0, 31)), rnd128(), clr);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule